// File: doc/BRIEF.md
# Auto-Restart Protection Supervisor

This block decides, cycle by cycle, whether a flyback power stage may switch. It receives already digitized comparator results: whether the supply rail is above the start level, whether it has sagged below the stop level, and four fault indications. The fault indications are feedback at the shutdown level, sync overvoltage, abnormal over-current and over-temperature. From these it drives a switching-enable, an enable for the high-voltage startup charger, and a code that names the cause of the last protective shutdown.

Any qualified fault stops switching and latches it off. The latch is released only when the rail has collapsed to the stop level. The charger then takes over again, and switching returns once the start level is reached. A fault that persists therefore produces a repeating cycle of charge, run and trip. The sync overvoltage indication must last for a blanking interval before it counts. The feedback-at-shutdown flag is filtered over a short qualification window. The abnormal over-current indication is honoured only while the gate is on.

Top module: `restart_supervisor`

## Requirements
- R1: While reset is held and after its release, switching is off, the charger is on and the fault code is 0.
- R2: While waiting in the charging phase, the charger stays on. If the start flag is high at a clock edge, from that edge onward switching is on and the charger is off.
- R3: Switching stays on while no fault trips. If the below-stop flag is high at a clock edge with no trip, the block returns to charging from that edge, and the fault code is unchanged.
- R4: While switching, an over-temperature flag sampled high stops switching at that edge and sets the fault code to 4.
- R5: While switching, the abnormal over-current flag trips with fault code 3 only when the gate-on input is also high. With the gate off, the flag has no effect.
- R6: While switching, sync overvoltage trips with fault code 2 only when it has been sampled high on OVP_BLANK_CYC consecutive edges. A shorter pulse has no effect.
- R7: While switching, the feedback-at-shutdown flag trips with fault code 1 only after FB_QUAL_CYC consecutive high samples. A shorter pulse has no effect.
- R8: After a trip, switching and the charger both stay off until the below-stop flag is sampled high. The start flag is ignored in this state.
- R9: From the tripped state, a high below-stop sample re-enters charging with the fault code held. The code returns to 0 at the edge where switching resumes.
- R10: When several faults qualify at the same edge, the recorded code follows the priority 4 over 3 over 2 over 1.
- R11: Fault flags sampled during the charging phase are ignored and do not stop the charger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_above_start | input | 1 | Supply rail at or above the start level |
| vcc_below_stop | input | 1 | Supply rail at or below the stop level |
| fb_at_shutdown | input | 1 | Feedback level has reached the shutdown level |
| sync_overvolt | input | 1 | Sync input above the overvoltage level |
| abn_overcur | input | 1 | Sense voltage above the abnormal over-current level |
| gate_on | input | 1 | Power switch gate currently driven on |
| over_temp | input | 1 | Die over-temperature |
| sw_enable | output | 1 | Switching permitted |
| charger_en | output | 1 | High-voltage startup charger enabled |
| fault_code | output | 3 | Cause of last shutdown: 0 none, 1 overload, 2 sync overvoltage, 3 abnormal over-current, 4 thermal |

## Verification
A wrong phase register shows up one clock later as a wrong sw_enable or charger_en pair. For example, a trip that fails to latch lets switching resume on the next start flag, and a missed release keeps both outputs low after the rail has collapsed. A persistence counter that is off by one moves the overvoltage or overload trip by one cycle relative to the reference model, which is visible on the first edge at which the two disagree. A wrong priority or a lost hold shows up in fault_code at the trip edge, or at the restart edge where it must fall back to 0.

// File: rtl/restart_pkg.sv
package restart_pkg;

    localparam int FCODE_W = 3;

    typedef enum logic [1:0] {
        PH_CHARGE = 2'd0,
        PH_RUN    = 2'd1,
        PH_HALT   = 2'd2
    } phase_e;

    typedef enum logic [FCODE_W-1:0] {
        FC_NONE     = 3'd0,
        FC_OVERLOAD = 3'd1,
        FC_SYNC_OV  = 3'd2,
        FC_ABN_OC   = 3'd3,
        FC_THERMAL  = 3'd4
    } fault_e;

    typedef struct packed {
        phase_e phase;
        fault_e code;
    } sup_state_t;

endpackage

// File: rtl/persist_filter.sv
// Reports a hit when a flag has been high on LEN consecutive armed edges.
module persist_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flag,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        if (arm && flag) begin
            hit = (cnt_q >= LAST);
            if (cnt_q < LAST) begin
                cnt_d = cnt_q + 1'b1;
            end
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fault_arbiter.sv
// Picks the highest-priority qualified fault.
module fault_arbiter
    import restart_pkg::*;
(
    input  logic   thermal,
    input  logic   abn_oc,
    input  logic   sync_ov,
    input  logic   overload,
    output logic   trip,
    output fault_e code
);
    always_comb begin
        trip = thermal | abn_oc | sync_ov | overload;
        if (thermal) begin
            code = FC_THERMAL;
        end else if (abn_oc) begin
            code = FC_ABN_OC;
        end else if (sync_ov) begin
            code = FC_SYNC_OV;
        end else if (overload) begin
            code = FC_OVERLOAD;
        end else begin
            code = FC_NONE;
        end
    end
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor
    import restart_pkg::*;
#(
    parameter int OVP_BLANK_CYC = 750,
    parameter int FB_QUAL_CYC   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_above_start,
    input  logic               vcc_below_stop,
    input  logic               fb_at_shutdown,
    input  logic               sync_overvolt,
    input  logic               abn_overcur,
    input  logic               gate_on,
    input  logic               over_temp,
    output logic               sw_enable,
    output logic               charger_en,
    output logic [FCODE_W-1:0] fault_code
);
    sup_state_t sup_d, sup_q;
    logic   running;
    logic   ovp_hit, olp_hit, trip;
    fault_e trip_code;

    assign running = (sup_q.phase == PH_RUN);

    persist_filter #(.LEN(OVP_BLANK_CYC)) u_ovp_blank (
        .clk(clk), .rst_n(rst_n), .arm(running),
        .flag(sync_overvolt), .hit(ovp_hit)
    );

    persist_filter #(.LEN(FB_QUAL_CYC)) u_olp_qual (
        .clk(clk), .rst_n(rst_n), .arm(running),
        .flag(fb_at_shutdown), .hit(olp_hit)
    );

    fault_arbiter u_arb (
        .thermal (running & over_temp),
        .abn_oc  (running & abn_overcur & gate_on),
        .sync_ov (ovp_hit),
        .overload(olp_hit),
        .trip    (trip),
        .code    (trip_code)
    );

    always_comb begin
        sup_d = sup_q;
        unique case (sup_q.phase)
            PH_CHARGE: begin
                if (vcc_above_start) begin
                    sup_d.phase = PH_RUN;
                    sup_d.code  = FC_NONE;
                end
            end
            PH_RUN: begin
                if (trip) begin
                    sup_d.phase = PH_HALT;
                    sup_d.code  = trip_code;
                end else if (vcc_below_stop) begin
                    sup_d.phase = PH_CHARGE;
                end
            end
            PH_HALT: begin
                if (vcc_below_stop) begin
                    sup_d.phase = PH_CHARGE;
                end
            end
            default: begin
                sup_d.phase = PH_CHARGE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_q.phase <= PH_CHARGE;
            sup_q.code  <= FC_NONE;
        end else begin
            sup_q <= sup_d;
        end
    end

    assign sw_enable  = running;
    assign charger_en = (sup_q.phase == PH_CHARGE);
    assign fault_code = sup_q.code;
endmodule

// File: rtl/restart_supervisor_chk.sv
module restart_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_above_start,
    input logic       vcc_below_stop,
    input logic       sync_overvolt,
    input logic       abn_overcur,
    input logic       gate_on,
    input logic       sw_enable,
    input logic       charger_en,
    input logic [2:0] fault_code
);
    // R2: switching only starts from a sampled start flag
    a_r2_start_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> $past(vcc_above_start));

    // R2: charger and switching never on together
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_enable && charger_en));

    // R8: tripped state held until below-stop is seen
    a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_enable && !charger_en && !vcc_below_stop) |=> (!sw_enable && !charger_en));

    // R5: abnormal over-current code only after gated flag
    a_r5_gate_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'd3 && $past(fault_code) != 3'd3) |-> $past(gate_on && abn_overcur));

    // R6: sync overvoltage code only after flag sampled high
    a_r6_ovp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'd2 && $past(fault_code) != 3'd2) |-> $past(sync_overvolt));

    // R9: code cleared on every restart
    a_r9_clear_on_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> (fault_code == 3'd0));
endmodule

bind restart_supervisor restart_supervisor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .vcc_above_start(vcc_above_start),
    .vcc_below_stop(vcc_below_stop), .sync_overvolt(sync_overvolt),
    .abn_overcur(abn_overcur), .gate_on(gate_on), .sw_enable(sw_enable),
    .charger_en(charger_en), .fault_code(fault_code)
);

// File: tb/restart_supervisor_tb.sv
`timescale 1ns/1ps
module restart_supervisor_tb_top;
    localparam int OVPN = 750;
    localparam int FBQN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b0, fb = 1'b0, sov = 1'b0;
    logic aoc = 1'b0, gate = 1'b0, otp = 1'b0;
    logic sw_enable, charger_en;
    logic [2:0] fault_code;

    always #2 clk = ~clk;

    restart_supervisor #(.OVP_BLANK_CYC(OVPN), .FB_QUAL_CYC(FBQN)) dut_i (
        .clk(clk), .rst_n(rst_n), .vcc_above_start(above), .vcc_below_stop(below),
        .fb_at_shutdown(fb), .sync_overvolt(sov), .abn_overcur(aoc),
        .gate_on(gate), .over_temp(otp), .sw_enable(sw_enable),
        .charger_en(charger_en), .fault_code(fault_code)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model: 0 charge, 1 run, 2 halted
    int m_st = 0;
    int m_code = 0;
    int ovp_run = 0;
    int olp_run = 0;

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_st = 0; m_code = 0; ovp_run = 0; olp_run = 0;
        end else begin
            case (m_st)
                0: begin
                    ovp_run = 0; olp_run = 0;
                    if (above) begin m_st = 1; m_code = 0; end
                end
                1: begin
                    int c;
                    ovp_run = sov ? ovp_run + 1 : 0;
                    olp_run = fb ? olp_run + 1 : 0;
                    c = 0;
                    if (otp) c = 4;
                    else if (aoc && gate) c = 3;
                    else if (ovp_run >= OVPN) c = 2;
                    else if (olp_run >= FBQN) c = 1;
                    if (c != 0) begin
                        m_st = 2; m_code = c; ovp_run = 0; olp_run = 0;
                    end else if (below) begin
                        m_st = 0; ovp_run = 0; olp_run = 0;
                    end
                end
                default: begin
                    ovp_run = 0; olp_run = 0;
                    if (below) m_st = 0;
                end
            endcase
        end
        #1;
        chk("sw_enable", int'(sw_enable), (m_st == 1) ? 1 : 0);
        chk("charger_en", int'(charger_en), (m_st == 0) ? 1 : 0);
        chk("fault_code", int'(fault_code), m_code);
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=200000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_above();
        above = 1'b1; wait_cyc(1); above = 1'b0; wait_cyc(2);
    endtask

    task automatic pulse_below();
        below = 1'b1; wait_cyc(1); below = 1'b0; wait_cyc(2);
    endtask

    task automatic recover();
        pulse_below();
        pulse_above();
    endtask

    initial begin
        @(negedge clk);
        tag = "R1";
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1 code after reset", int'(fault_code), 0);

        tag = "R11";
        otp = 1'b1; aoc = 1'b1; gate = 1'b1; fb = 1'b1; sov = 1'b1;
        wait_cyc(6);
        chk("R11 charger held", int'(charger_en), 1);
        otp = 1'b0; aoc = 1'b0; gate = 1'b0; fb = 1'b0; sov = 1'b0;
        wait_cyc(1);

        tag = "R2";
        pulse_above();
        chk("R2 running", int'(sw_enable), 1);

        tag = "R3";
        wait_cyc(5);
        pulse_below();
        chk("R3 back to charging", int'(charger_en), 1);
        pulse_above();

        tag = "R4";
        otp = 1'b1; wait_cyc(1); otp = 1'b0; wait_cyc(2);
        chk("R4 thermal code", int'(fault_code), 4);

        tag = "R8";
        pulse_above();
        chk("R8 start ignored", int'(sw_enable), 0);
        wait_cyc(5);

        tag = "R9";
        pulse_below();
        chk("R9 code held in charging", int'(fault_code), 4);
        pulse_above();
        chk("R9 code cleared on restart", int'(fault_code), 0);

        tag = "R5";
        aoc = 1'b1; gate = 1'b0; wait_cyc(10);
        chk("R5 no trip gate off", int'(sw_enable), 1);
        gate = 1'b1; wait_cyc(1); aoc = 1'b0; gate = 1'b0; wait_cyc(2);
        chk("R5 abn oc code", int'(fault_code), 3);
        recover();

        tag = "R6";
        sov = 1'b1; wait_cyc(OVPN - 1); sov = 1'b0; wait_cyc(3);
        chk("R6 short pulse ignored", int'(sw_enable), 1);
        sov = 1'b1; wait_cyc(OVPN); sov = 1'b0; wait_cyc(2);
        chk("R6 ovp code", int'(fault_code), 2);
        recover();

        tag = "R7";
        fb = 1'b1; wait_cyc(FBQN - 1); fb = 1'b0; wait_cyc(3);
        chk("R7 short pulse ignored", int'(sw_enable), 1);
        fb = 1'b1; wait_cyc(FBQN); fb = 1'b0; wait_cyc(2);
        chk("R7 overload code", int'(fault_code), 1);
        recover();

        tag = "R10";
        otp = 1'b1; aoc = 1'b1; gate = 1'b1; wait_cyc(1);
        otp = 1'b0; aoc = 1'b0; gate = 1'b0; wait_cyc(2);
        chk("R10 thermal wins", int'(fault_code), 4);
        recover();
        fb = 1'b1; wait_cyc(FBQN - 1);
        aoc = 1'b1; gate = 1'b1; wait_cyc(1);
        fb = 1'b0; aoc = 1'b0; gate = 1'b0; wait_cyc(2);
        chk("R10 abn oc over overload", int'(fault_code), 3);
        recover();

        tag = "R1";
        rst_n = 1'b0; wait_cyc(2);
        chk("R1 reset charger", int'(charger_en), 1);
        rst_n = 1'b1; wait_cyc(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule